// File: doc/BRIEF.md
# Message-Signaled Interrupt Aggregator

The block gathers up to 32 level-sensitive interrupt lines into one set of memory-mapped registers: a pending vector, a request vector, a mask, a control bit and a target word. When an enabled line goes active, the block does not drive an interrupt wire. It issues one posted 32-bit write on an outbound bus-master port instead. The address of that write is the target word with its five low bits cleared, and the data is those five low bits. The receiving processor decodes the data as a vector number.

Software reaches the registers through a simple word-wide slave port with byte-lane enables, in big-endian lane order. The register space also holds an error-log word, an arbitration-mode scratch word, several locations that always read zero, and a power-control location. Writing the power-off code to power control produces a one-cycle shutdown pulse. A control bit can inhibit outbound writes without stopping the request bookkeeping. Edges that arrive while a write waits for its acknowledge are merged into one follow-up write.

Top module: `irq_msg_agg`

## Requirements
- R1: Every clock in which irqIn[i] is high sets pending bit i on that edge, whatever the mask. Pending is read at byte offset 0x08.
- R2: A read of pending returns its value and clears it on the same edge. Any write to offset 0x08 also clears it. A line still held high sets its bit again.
- R3: When irqIn[i] and mask bit i are both high, request bit i is set. The mask is at offset 0x00 and request at offset 0x04. Writes to request have no effect, and only reset clears it.
- R4: A rising edge on an input whose mask bit is set starts one outbound write. The write has mstAddr = target & ~0x1F and mstData = target[4:0], zero-extended. The target is at offset 0x10. A line held high causes no further writes.
- R5: Control is at offset 0x0C. While control bit 0 is set, no outbound write starts, but request bits are still set. A read of control returns bit 0 alone, with bits 31:1 at zero.
- R6: After reset the target reads 0xFFFB0003, mask, pending and request read zero, and mstReq and shutdownReq are low.
- R7: Rising edges that arrive while a write waits for mstAck are merged into a single queued write. That write is issued with the target value current at the acknowledge.
- R8: mstReq, mstAddr and mstData stay unchanged from the cycle mstReq rises until the edge at which mstAck is sampled high.
- R9: The write data after lane masking is tested against 0x00000002 on a write to offset 0x20. A match raises shutdownReq for exactly one cycle, and any other value raises nothing. Offsets 0x20, 0x24 and 0x28, the windows 0x30, 0x34 and 0x38, and every unmapped offset read zero.
- R10: The error log (offset 0x14) and the arbitration scratch (offset 0x18) take byte-lane writes. regBe[3] enables bits 31:24 (byte offset 0), down to regBe[0] for bits 7:0. Lanes that are not enabled keep their value.
- R11: regRdata is loaded on the edge where regRd is sampled high. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| regAddr | input | 8 | Register byte offset, word aligned |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regBe | input | 4 | Byte-lane enables, bit 3 = byte offset 0 = bits 31:24 |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, registered |
| irqIn | input | 32 | Level interrupt inputs |
| mstReq | output | 1 | Outbound write request |
| mstAddr | output | 32 | Outbound write address |
| mstData | output | 32 | Outbound write data |
| mstAck | input | 1 | Outbound write acknowledge |
| shutdownReq | output | 1 | One-cycle power-off pulse |

## Verification
The assertions assume a bus partner that raises mstAck only while mstReq is high and holds it for one cycle per transfer. They also assume that regRd and regWr are never high in the same cycle. The bench's acknowledge responder keeps to this: it raises mstAck only after it has seen mstReq high, and drops it on the following cycle. The register tasks drive a single strobe per access. All stimulus changes on the falling edge, so interrupt edges and register accesses never coincide with the sampling edge.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  localparam int REG_AW = 8;

  localparam logic [REG_AW-1:0] OFS_MASK    = 8'h00;
  localparam logic [REG_AW-1:0] OFS_REQ     = 8'h04;
  localparam logic [REG_AW-1:0] OFS_PEND    = 8'h08;
  localparam logic [REG_AW-1:0] OFS_CTRL    = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_TARGET  = 8'h10;
  localparam logic [REG_AW-1:0] OFS_ERRLOG  = 8'h14;
  localparam logic [REG_AW-1:0] OFS_ARB     = 8'h18;
  localparam logic [REG_AW-1:0] OFS_POWER   = 8'h20;

  localparam logic [31:0] TARGET_RESET   = 32'hFFFB_0003;
  localparam logic [31:0] POWER_OFF_CODE = 32'h0000_0002;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_MASK, SEL_REQ, SEL_PEND,
    SEL_CTRL, SEL_TARGET, SEL_ERRLOG, SEL_ARB
  } rdSel_t;

  typedef struct packed {
    logic   wrMask;
    logic   wrCtrl;
    logic   wrTarget;
    logic   wrErrLog;
    logic   wrArb;
    logic   clrPend;
    logic   readCap;
    rdSel_t rdSel;
  } regStrobe_t;
endpackage

// File: rtl/irq_msg_regs.sv
module irq_msg_regs
  import irq_msg_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  regStrobe_t    strobe,
  input  logic [DW-1:0] laneMask,
  input  logic [DW-1:0] regWdata,
  input  logic [DW-1:0] irqIn,
  output logic [DW-1:0] regRdata,
  output logic [DW-1:0] maskVec,
  output logic [DW-1:0] pendVec,
  output logic [DW-1:0] reqVec,
  output logic [DW-1:0] targetReg,
  output logic          inhibit
);
  logic [DW-1:0] errLog;
  logic [DW-1:0] arbMode;
  logic [DW-1:0] readMux;

  function automatic logic [DW-1:0] laneMerge(input logic [DW-1:0] oldVal);
    return (oldVal & ~laneMask) | (regWdata & laneMask);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      maskVec   <= '0;
      pendVec   <= '0;
      reqVec    <= '0;
      targetReg <= TARGET_RESET[DW-1:0];
      inhibit   <= 1'b0;
      errLog    <= '0;
      arbMode   <= '0;
    end else begin
      pendVec <= (strobe.clrPend ? '0 : pendVec) | irqIn;
      reqVec  <= reqVec | (irqIn & maskVec);
      if (strobe.wrMask)   maskVec   <= laneMerge(maskVec);
      if (strobe.wrTarget) targetReg <= laneMerge(targetReg);
      if (strobe.wrErrLog) errLog    <= laneMerge(errLog);
      if (strobe.wrArb)    arbMode   <= laneMerge(arbMode);
      if (strobe.wrCtrl && laneMask[0]) inhibit <= regWdata[0];
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_MASK:   readMux = maskVec;
      SEL_REQ:    readMux = reqVec;
      SEL_PEND:   readMux = pendVec;
      SEL_CTRL:   readMux = {{(DW-1){1'b0}}, inhibit};
      SEL_TARGET: readMux = targetReg;
      SEL_ERRLOG: readMux = errLog;
      SEL_ARB:    readMux = arbMode;
      default:    readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) regRdata <= '0;
    else if (strobe.readCap) regRdata <= readMux;
  end
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
  import irq_msg_pkg::*;
#(
  parameter int DW         = 32,
  parameter int ALIGN_BITS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DW/8-1:0]   regBe,
  input  logic [DW-1:0]     regWdata,
  input  logic [DW-1:0]     irqIn,
  input  logic [DW-1:0]     maskVec,
  input  logic              inhibit,
  input  logic [DW-1:0]     targetReg,
  input  logic              mstAck,
  output regStrobe_t        strobe,
  output logic [DW-1:0]     laneMask,
  output logic              mstReq,
  output logic [DW-1:0]     mstAddr,
  output logic [DW-1:0]     mstData,
  output logic              shutdownReq
);
  localparam int LANES = DW / 8;
  localparam logic [DW-1:0] LOW_MASK = DW'((1 << ALIGN_BITS) - 1);

  typedef enum logic {ST_IDLE, ST_SEND} sendState_t;

  sendState_t    state;
  logic          queued;
  logic [DW-1:0] irqQ;
  logic          fire;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneMask[8*i +: 8] = {8{regBe[i]}};
  end

  always_comb begin
    strobe         = '0;
    strobe.readCap = regRd;
    strobe.rdSel   = SEL_ZERO;
    case (regAddr)
      OFS_MASK:   begin strobe.wrMask   = regWr; strobe.rdSel = SEL_MASK;   end
      OFS_REQ:    begin                          strobe.rdSel = SEL_REQ;    end
      OFS_PEND:   begin strobe.clrPend  = regWr | regRd; strobe.rdSel = SEL_PEND; end
      OFS_CTRL:   begin strobe.wrCtrl   = regWr; strobe.rdSel = SEL_CTRL;   end
      OFS_TARGET: begin strobe.wrTarget = regWr; strobe.rdSel = SEL_TARGET; end
      OFS_ERRLOG: begin strobe.wrErrLog = regWr; strobe.rdSel = SEL_ERRLOG; end
      OFS_ARB:    begin strobe.wrArb    = regWr; strobe.rdSel = SEL_ARB;    end
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) shutdownReq <= 1'b0;
    else shutdownReq <= regWr && (regAddr == OFS_POWER)
                        && ((regWdata & laneMask) == POWER_OFF_CODE[DW-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) irqQ <= '0;
    else irqQ <= irqIn;
  end

  assign fire   = (|(irqIn & ~irqQ & maskVec)) & ~inhibit;
  assign mstReq = (state == ST_SEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      queued  <= 1'b0;
      mstAddr <= '0;
      mstData <= '0;
    end else begin
      case (state)
        ST_IDLE: if (fire) begin
          state   <= ST_SEND;
          mstAddr <= targetReg & ~LOW_MASK;
          mstData <= targetReg & LOW_MASK;
        end
        ST_SEND: if (mstAck) begin
          if (queued || fire) begin
            mstAddr <= targetReg & ~LOW_MASK;
            mstData <= targetReg & LOW_MASK;
            queued  <= queued & fire;
          end else begin
            state <= ST_IDLE;
          end
        end else if (fire) begin
          queued <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_msg_agg.sv
module irq_msg_agg
  import irq_msg_pkg::*;
#(
  parameter int DW         = 32,
  parameter int ALIGN_BITS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DW/8-1:0]   regBe,
  input  logic [DW-1:0]     regWdata,
  output logic [DW-1:0]     regRdata,
  input  logic [DW-1:0]     irqIn,
  output logic              mstReq,
  output logic [DW-1:0]     mstAddr,
  output logic [DW-1:0]     mstData,
  input  logic              mstAck,
  output logic              shutdownReq
);
  regStrobe_t    strobe;
  logic [DW-1:0] laneMask;
  logic [DW-1:0] maskVec;
  logic [DW-1:0] pendVec;
  logic [DW-1:0] reqVec;
  logic [DW-1:0] targetReg;
  logic          inhibit;

  irq_msg_ctrl #(.DW(DW), .ALIGN_BITS(ALIGN_BITS)) u_ctrl (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regBe(regBe), .regWdata(regWdata), .irqIn(irqIn), .maskVec(maskVec),
    .inhibit(inhibit), .targetReg(targetReg), .mstAck(mstAck),
    .strobe(strobe), .laneMask(laneMask), .mstReq(mstReq),
    .mstAddr(mstAddr), .mstData(mstData), .shutdownReq(shutdownReq)
  );

  irq_msg_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .strobe(strobe), .laneMask(laneMask),
    .regWdata(regWdata), .irqIn(irqIn), .regRdata(regRdata),
    .maskVec(maskVec), .pendVec(pendVec), .reqVec(reqVec),
    .targetReg(targetReg), .inhibit(inhibit)
  );
endmodule

// File: rtl/irq_msg_chk.sv
module irq_msg_chk #(
  parameter int DW         = 32,
  parameter int ALIGN_BITS = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] irqIn,
  input logic [DW-1:0] pendVec,
  input logic [DW-1:0] reqVec,
  input logic          mstReq,
  input logic          mstAck,
  input logic [DW-1:0] mstAddr,
  input logic [DW-1:0] mstData,
  input logic          shutdownReq
);
  assert_pend_level_R1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((pendVec & $past(irqIn)) == $past(irqIn)));

  assert_req_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((reqVec & $past(reqVec)) == $past(reqVec)));

  assert_addr_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    mstReq |-> (mstAddr[ALIGN_BITS-1:0] == '0));

  assert_data_narrow_R4: assert property (@(posedge clk) disable iff (rst)
    mstReq |-> (mstData[DW-1:ALIGN_BITS] == '0));

  assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (mstReq && !mstAck) |=> (mstReq && $stable(mstAddr) && $stable(mstData)));

  assert_shutdown_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    shutdownReq |=> !shutdownReq);
endmodule

bind irq_msg_agg irq_msg_chk #(.DW(DW), .ALIGN_BITS(ALIGN_BITS)) u_chk (
  .clk(clk), .rst(rst), .irqIn(irqIn), .pendVec(pendVec), .reqVec(reqVec),
  .mstReq(mstReq), .mstAck(mstAck), .mstAddr(mstAddr), .mstData(mstData),
  .shutdownReq(shutdownReq)
);

// File: tb/sim_irq_msg_agg.sv
module sim_irq_msg_agg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [3:0]  regBe = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] irqIn = '0;
  logic        mstReq;
  logic [31:0] mstAddr;
  logic [31:0] mstData;
  logic        mstAck = 1'b0;
  logic        shutdownReq;

  int checks = 0;
  int failures = 0;
  int ackDelay = 2;
  int waitCnt = 0;
  int sendCount = 0;
  int shutCount = 0;
  logic [31:0] firstAddr;
  logic [31:0] firstData;
  logic [63:0] expQ[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_msg_agg u0 (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regBe(regBe), .regWdata(regWdata), .regRdata(regRdata), .irqIn(irqIn),
    .mstReq(mstReq), .mstAddr(mstAddr), .mstData(mstData), .mstAck(mstAck),
    .shutdownReq(shutdownReq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pushSend(logic [31:0] target);
    expQ.push_back({target & 32'hFFFF_FFE0, target & 32'h1F});
  endtask

  task automatic wr(logic [7:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regBe = be; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    check(tag, regRdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor and acknowledge responder: pops the scoreboard at each handshake.
  always @(negedge clk) begin
    if (shutdownReq) shutCount++;
    if (mstAck) begin
      mstAck = 1'b0;
      waitCnt = 0;
    end else if (mstReq) begin
      if (waitCnt == 0) begin
        firstAddr = mstAddr;
        firstData = mstData;
      end
      if (waitCnt >= ackDelay) begin
        mstAck = 1'b1;
        sendCount++;
        check("R8 address held", mstAddr, firstAddr);
        check("R8 data held", mstData, firstData);
        if (expQ.size() == 0) begin
          checks++; failures++;
          $display("FAIL R4 unexpected send actual=%h expected=none", mstAddr);
        end else begin
          logic [63:0] e;
          e = expQ.pop_front();
          check("R4 send address", mstAddr, e[63:32]);
          check("R4 send data", mstData, e[31:0]);
        end
      end else begin
        waitCnt++;
      end
    end
  end

  initial begin
    int base;
    idle(3);
    rst = 1'b0;
    // R6 reset state
    check("R6 mstReq at reset", {31'b0, mstReq}, 32'h0);
    check("R6 shutdownReq at reset", {31'b0, shutdownReq}, 32'h0);
    rd(8'h10, 32'hFFFB_0003, "R6 target reset");
    rd(8'h00, 32'h0, "R6 mask reset");
    rd(8'h08, 32'h0, "R6 pending reset");
    rd(8'h04, 32'h0, "R6 request reset");

    // R1 masked line still pends; R2 read clears
    irqIn[0] = 1'b1; idle(2); irqIn[0] = 1'b0; idle(1);
    rd(8'h08, 32'h1, "R1 pending set while masked");
    rd(8'h08, 32'h0, "R2 pending cleared by read");
    rd(8'h04, 32'h0, "R3 request not set while masked");

    // R4 enabled edge sends once, held level does not repeat
    wr(8'h00, 4'hF, 32'h8);
    pushSend(32'hFFFB_0003);
    irqIn[3] = 1'b1; idle(40);
    check("R4 queue drained", expQ.size(), 0);
    check("R4 held level one send", sendCount, 1);
    rd(8'h04, 32'h8, "R3 request set");
    wr(8'h04, 4'hF, 32'h0);
    rd(8'h04, 32'h8, "R3 request write ignored");
    irqIn[3] = 1'b0; idle(1);
    wr(8'h08, 4'hF, 32'hFFFF_FFFF);
    rd(8'h08, 32'h0, "R2 pending cleared by write");

    // R4 new target
    wr(8'h10, 4'hF, 32'h1000_0045);
    pushSend(32'h1000_0045);
    irqIn[3] = 1'b1; idle(30);
    check("R4 new target drained", expQ.size(), 0);
    check("R4 second send count", sendCount, 2);
    irqIn[3] = 1'b0;

    // R10 byte lanes
    wr(8'h14, 4'hF, 32'h1122_3344);
    wr(8'h14, 4'b1000, 32'hAA00_0000);
    rd(8'h14, 32'hAA22_3344, "R10 errlog top lane");
    wr(8'h18, 4'b0001, 32'hFFFF_FFCC);
    wr(8'h18, 4'b0100, 32'h0055_0000);
    rd(8'h18, 32'h0055_00CC, "R10 arb lanes");

    // R5 inhibit
    wr(8'h0C, 4'hF, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h1, "R5 control reads bit0 only");
    wr(8'h00, 4'hF, 32'h28);
    irqIn[5] = 1'b1; idle(12);
    check("R5 no send while inhibited", sendCount, 2);
    rd(8'h04, 32'h28, "R5 request set while inhibited");
    irqIn[5] = 1'b0;
    wr(8'h0C, 4'hF, 32'h0);

    // R7 merge edges during wait
    ackDelay = 20;
    wr(8'h00, 4'hF, 32'h6);
    base = sendCount;
    pushSend(32'h1000_0045);
    pushSend(32'h1000_0045);
    irqIn[1] = 1'b1; idle(3);
    irqIn[2] = 1'b1; idle(2);
    irqIn[2] = 1'b0; idle(2);
    irqIn[2] = 1'b1; idle(70);
    check("R7 merged queue drained", expQ.size(), 0);
    check("R7 exactly two sends", sendCount - base, 2);
    irqIn = '0;
    ackDelay = 2;

    // R9 shutdown and zero locations
    wr(8'h20, 4'hF, 32'h3); idle(3);
    check("R9 no pulse for other code", shutCount, 0);
    wr(8'h20, 4'b0001, 32'h0000_0002); idle(3);
    check("R9 pulse for power-off code", shutCount, 1);
    wr(8'h20, 4'hF, 32'hFF00_0002); idle(3);
    check("R9 masked mismatch no pulse", shutCount, 1);
    wr(8'h20, 4'b0001, 32'hFF00_0002); idle(3);
    check("R9 lane-masked match pulses", shutCount, 2);
    rd(8'h20, 32'h0, "R9 power reads zero");
    rd(8'h24, 32'h0, "R9 version reads zero");
    rd(8'h28, 32'h0, "R9 io-reset reads zero");
    rd(8'h34, 32'h0, "R9 window reads zero");
    rd(8'h3C, 32'h0, "R9 unmapped reads zero");

    // R11 read data holds
    rd(8'h10, 32'h1000_0045, "R11 target read");
    idle(5);
    check("R11 rdata held", regRdata, 32'h1000_0045);

    idle(10);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule